// File: doc/BRIEF.md
# Power-mode state transition timer

This block is the inactivity timer and mode sequencer of a power management unit. It holds the current power mode and steps it through a fixed chain: high-speed, low-speed, doze, sleep, suspend and finally off. A hidden up-counter measures how long the system has been idle in the current mode. When the count passes that mode's programmed timeout, the block moves one step down the chain and restarts the count from zero.

Each mode except off has its own 8-bit timeout value and its own time base. The time base is one of several single-cycle tick strobes supplied from outside. Two resolution bits pick a coarser tick for the two fastest modes. A timeout value of zero parks the sequencer in that mode.

An activity pulse brings the block back to high-speed. A forced request, from a pin or a software write decoded elsewhere, puts it straight into any mode. Both of these clear the counter. Clock switching, activity detection and register decode sit outside this block.

Top module: `pwr_mode_timer`

## Requirements
- R1: After reset the mode output is high-speed (code 0) and the idle count is zero. With a high-speed timeout of 1, the first high-speed tick keeps the mode, and the second tick moves it to low-speed.
- R2: Mode codes are high-speed 0, low-speed 1, doze 2, sleep 3, suspend 4 and off 5. Without force or activity, the mode changes only to the next code in that order. Off (5) is never left without force or activity.
- R3: With a timeout value N (1..255), the mode advances on the (N+1)-th selected tick after the count was last cleared, because the count must exceed N. The new mode shows on mode_o one clock after the edge that samples that tick.
- R4: In high-speed, the count advances on tick_2ms_i when res_hs_i is 0 and on tick_62ms_i when res_hs_i is 1. All other ticks have no effect.
- R5: In low-speed, the count advances on tick_62ms_i when res_ls_i is 0 and on tick_250ms_i when res_ls_i is 1. All other ticks have no effect.
- R6: Doze counts only tick_4s_i, sleep counts only tick_62ms_i, and suspend counts only tick_64s_i.
- R7: While the current mode's timeout value is zero, the count is held at zero and the mode never advances, however many ticks arrive. Once a nonzero value is written, the count starts again from zero.
- R8: An activity pulse sets the mode to high-speed on the next clock and clears the count. This also applies when the mode is off.
- R9: A force request loads force_mode_i as the mode on the next clock (codes 6 and 7 select off) and clears the count. Force wins over an activity pulse or a timeout expiry in the same cycle.
- R10: A change to a timeout value or a resolution bit in the middle of a count does not clear the count. It applies at the next selected tick, so a value lowered to or below the current count expires on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lim_hs_i | input | 8 | High-speed timeout value |
| lim_ls_i | input | 8 | Low-speed timeout value |
| lim_doze_i | input | 8 | Doze timeout value |
| lim_sleep_i | input | 8 | Sleep timeout value |
| lim_susp_i | input | 8 | Suspend timeout value |
| res_hs_i | input | 1 | Coarse time base select for high-speed |
| res_ls_i | input | 1 | Coarse time base select for low-speed |
| tick_2ms_i | input | 1 | Strobe every 1/512 s |
| tick_62ms_i | input | 1 | Strobe every 1/16 s |
| tick_250ms_i | input | 1 | Strobe every 1/4 s |
| tick_4s_i | input | 1 | Strobe every 4 s |
| tick_64s_i | input | 1 | Strobe every 64 s |
| activity_i | input | 1 | Activity pulse, returns to high-speed |
| force_i | input | 1 | Force mode request |
| force_mode_i | input | 3 | Mode code to force |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the block with its default 8-bit timeout width. At that width the whole range of timeout values, 1 through 255, is small enough to sweep completely. For every value it checks that the mode holds after exactly N selected ticks, ignores the other tick lines, and advances on the next selected tick. The bench drives the tick strobes one by one instead of using real rates, so each mode's time base, the frozen zero setting and the force and activity priorities can all be reached in a few thousand cycles.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [2:0] {
    MODE_HS    = 3'd0,
    MODE_LS    = 3'd1,
    MODE_DOZE  = 3'd2,
    MODE_SLEEP = 3'd3,
    MODE_SUSP  = 3'd4,
    MODE_OFF   = 3'd5
  } mode_e;

  localparam int NUM_MODES = 6;
  localparam int NUM_TIMED = NUM_MODES - 1;
  localparam int NUM_TICKS = 5;

  // tick vector positions
  localparam int TK_2MS   = 0;
  localparam int TK_62MS  = 1;
  localparam int TK_250MS = 2;
  localparam int TK_4S    = 3;
  localparam int TK_64S   = 4;
endpackage

// File: rtl/pmt_tick_sel.sv
module pmt_tick_sel
  import pmt_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  mode_e                            mode_i,
  input  logic [NUM_TIMED-1:0][LIM_W-1:0]  lims_i,
  input  logic [NUM_TICKS-1:0]             ticks_i,
  input  logic                             res_hs_i,
  input  logic                             res_ls_i,
  output logic                             tick_o,
  output logic [LIM_W-1:0]                 lim_o
);
  always_comb begin
    tick_o = 1'b0;
    lim_o  = '0;
    unique case (mode_i)
      MODE_HS: begin
        tick_o = res_hs_i ? ticks_i[TK_62MS] : ticks_i[TK_2MS];
        lim_o  = lims_i[0];
      end
      MODE_LS: begin
        tick_o = res_ls_i ? ticks_i[TK_250MS] : ticks_i[TK_62MS];
        lim_o  = lims_i[1];
      end
      MODE_DOZE: begin
        tick_o = ticks_i[TK_4S];
        lim_o  = lims_i[2];
      end
      MODE_SLEEP: begin
        tick_o = ticks_i[TK_62MS];
        lim_o  = lims_i[3];
      end
      MODE_SUSP: begin
        tick_o = ticks_i[TK_64S];
        lim_o  = lims_i[4];
      end
      default: begin
        tick_o = 1'b0; // off: terminal, no time base
        lim_o  = '0;
      end
    endcase
  end
endmodule

// File: rtl/pmt_idle_cnt.sv
module pmt_idle_cnt #(
  parameter int LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             expire_o
);
  logic [LIM_W-1:0] cnt_q;
  logic             frozen;

  assign frozen   = (lim_i == '0);
  // count must exceed the limit: expiry on the tick after reaching it
  assign expire_o = tick_i && !frozen && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || frozen || expire_o) cnt_q <= '0;
    else if (tick_i)                    cnt_q <= cnt_q + 1'b1;
  end

  assert_zero_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i == '0) |=> (cnt_q == '0));
  assert_clear_on_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_restart_after_expiry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
  assert_no_count_without_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pmt_mode_seq.sv
module pmt_mode_seq
  import pmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       force_i,
  input  logic [2:0] force_mode_i,
  input  logic       activity_i,
  input  logic       expire_i,
  output mode_e      mode_o
);
  mode_e mode_q;
  mode_e force_tgt;

  assign force_tgt = (force_mode_i > 3'(MODE_OFF)) ? MODE_OFF : mode_e'(force_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mode_q <= MODE_HS;
    else if (force_i)                     mode_q <= force_tgt;
    else if (activity_i)                  mode_q <= MODE_HS;
    else if (expire_i && mode_q != MODE_OFF) mode_q <= mode_e'(mode_q + 3'd1);
  end

  assign mode_o = mode_q;

  assert_force_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (mode_q == (($past(force_mode_i) > 3'd5) ? MODE_OFF : mode_e'($past(force_mode_i)))));
  assert_activity_home_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (activity_i && !force_i) |=> (mode_q == MODE_HS));
  assert_step_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !activity_i && expire_i && mode_q != MODE_OFF)
      |=> (3'(mode_q) == 3'($past(mode_q)) + 3'd1));
  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !activity_i && !expire_i) |=> $stable(mode_q));
  assert_off_terminal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF && !force_i && !activity_i) |=> (mode_q == MODE_OFF));
endmodule

// File: rtl/pwr_mode_timer.sv
module pwr_mode_timer
  import pmt_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LIM_W-1:0] lim_hs_i,
  input  logic [LIM_W-1:0] lim_ls_i,
  input  logic [LIM_W-1:0] lim_doze_i,
  input  logic [LIM_W-1:0] lim_sleep_i,
  input  logic [LIM_W-1:0] lim_susp_i,
  input  logic             res_hs_i,
  input  logic             res_ls_i,
  input  logic             tick_2ms_i,
  input  logic             tick_62ms_i,
  input  logic             tick_250ms_i,
  input  logic             tick_4s_i,
  input  logic             tick_64s_i,
  input  logic             activity_i,
  input  logic             force_i,
  input  logic [2:0]       force_mode_i,
  output logic [2:0]       mode_o
);
  logic [NUM_TIMED-1:0][LIM_W-1:0] lims;
  logic [NUM_TICKS-1:0]            ticks;
  mode_e                           mode;
  logic                            tick_sel;
  logic [LIM_W-1:0]                lim_sel;
  logic                            expire;

  assign lims  = {lim_susp_i, lim_sleep_i, lim_doze_i, lim_ls_i, lim_hs_i};
  assign ticks = {tick_64s_i, tick_4s_i, tick_250ms_i, tick_62ms_i, tick_2ms_i};

  pmt_tick_sel #(.LIM_W(LIM_W)) u_sel (
    .mode_i   (mode),
    .lims_i   (lims),
    .ticks_i  (ticks),
    .res_hs_i (res_hs_i),
    .res_ls_i (res_ls_i),
    .tick_o   (tick_sel),
    .lim_o    (lim_sel)
  );

  pmt_idle_cnt #(.LIM_W(LIM_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (force_i | activity_i),
    .tick_i   (tick_sel),
    .lim_i    (lim_sel),
    .expire_o (expire)
  );

  pmt_mode_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .force_i      (force_i),
    .force_mode_i (force_mode_i),
    .activity_i   (activity_i),
    .expire_i     (expire),
    .mode_o       (mode)
  );

  assign mode_o = 3'(mode);
endmodule

// File: tb/pwr_mode_timer_test.sv
module pwr_mode_timer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lim_hs = 8'd1, lim_ls = 8'd1, lim_doze = 8'd1, lim_sleep = 8'd1, lim_susp = 8'd1;
  logic       res_hs = 1'b0, res_ls = 1'b0;
  logic [4:0] tk = '0;
  logic       act = 1'b0, frc = 1'b0;
  logic [2:0] fmode = '0;
  logic [2:0] mode;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_timer uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lim_hs_i(lim_hs), .lim_ls_i(lim_ls), .lim_doze_i(lim_doze),
    .lim_sleep_i(lim_sleep), .lim_susp_i(lim_susp),
    .res_hs_i(res_hs), .res_ls_i(res_ls),
    .tick_2ms_i(tk[0]), .tick_62ms_i(tk[1]), .tick_250ms_i(tk[2]),
    .tick_4s_i(tk[3]), .tick_64s_i(tk[4]),
    .activity_i(act), .force_i(frc), .force_mode_i(fmode),
    .mode_o(mode)
  );

  task automatic chk(string tag, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: mode=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic tick(int k);
    @(negedge clk); tk = '0; tk[k] = 1'b1;
    @(negedge clk); tk = '0;
  endtask

  task automatic force_to(int m);
    @(negedge clk); frc = 1'b1; fmode = 3'(m);
    @(negedge clk); frc = 1'b0;
  endtask

  task automatic activity();
    @(negedge clk); act = 1'b1;
    @(negedge clk); act = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    tick(0); chk("R1 count from zero", mode, 0);
    tick(0); chk("R1 second tick", mode, 1);

    // R3/R4 sweep of every high-speed value
    for (int n = 1; n <= 255; n++) begin
      lim_hs = 8'(n);
      force_to(0);
      repeat (n) tick(0);
      chk("R3 hold at N ticks", mode, 0);
      for (int k = 1; k < 5; k++) tick(k);
      chk("R4 other ticks ignored", mode, 0);
      tick(0);
      chk("R3 expire at N+1", mode, 1);
    end

    // R4 coarse base
    lim_hs = 8'd3; res_hs = 1'b1; force_to(0);
    repeat (5) tick(0);
    chk("R4 fine tick ignored", mode, 0);
    repeat (3) tick(1); chk("R4 coarse hold", mode, 0);
    tick(1); chk("R4 coarse expire", mode, 1);
    res_hs = 1'b0;

    // R5
    lim_ls = 8'd2; force_to(1);
    repeat (2) tick(1); chk("R5 fine hold", mode, 1);
    tick(1); chk("R5 fine expire", mode, 2);
    res_ls = 1'b1; force_to(1);
    repeat (4) tick(1); chk("R5 fine ignored", mode, 1);
    repeat (2) tick(2); chk("R5 coarse hold", mode, 1);
    tick(2); chk("R5 coarse expire", mode, 2);
    res_ls = 1'b0;

    // R2/R6 full chain
    lim_hs = 1; lim_ls = 1; lim_doze = 1; lim_sleep = 1; lim_susp = 1;
    force_to(0);
    repeat (2) tick(0); chk("R2 hs->ls", mode, 1);
    repeat (2) tick(1); chk("R2 ls->doze", mode, 2);
    for (int k = 0; k < 5; k++) if (k != 3) tick(k);
    chk("R6 doze ignores others", mode, 2);
    repeat (2) tick(3); chk("R6 doze->sleep", mode, 3);
    tick(0); tick(2); tick(3); tick(4);
    chk("R6 sleep ignores others", mode, 3);
    repeat (2) tick(1); chk("R6 sleep->susp", mode, 4);
    tick(0); tick(1); tick(2); tick(3);
    chk("R6 susp ignores others", mode, 4);
    repeat (2) tick(4); chk("R6 susp->off", mode, 5);
    for (int r = 0; r < 4; r++) for (int k = 0; k < 5; k++) tick(k);
    chk("R2 off terminal", mode, 5);

    // R7
    lim_doze = 8'd0; force_to(2);
    repeat (300) tick(3);
    chk("R7 frozen", mode, 2);
    lim_doze = 8'd1;
    tick(3); chk("R7 restart hold", mode, 2);
    tick(3); chk("R7 restart expire", mode, 3);

    // R8
    lim_ls = 8'd5; force_to(1);
    repeat (3) tick(1); activity();
    chk("R8 activity to hs", mode, 0);
    lim_hs = 8'd3;
    repeat (3) tick(0); activity();
    repeat (3) tick(0); chk("R8 count cleared", mode, 0);
    tick(0); chk("R8 after clear expire", mode, 1);
    force_to(5); activity(); chk("R8 wake from off", mode, 0);

    // R9
    for (int m = 0; m < 8; m++) begin
      force_to(m);
      chk("R9 force code", mode, (m > 5) ? 5 : m);
    end
    @(negedge clk); frc = 1'b1; fmode = 3'd3; act = 1'b1;
    @(negedge clk); frc = 1'b0; act = 1'b0;
    chk("R9 force over activity", mode, 3);
    lim_hs = 8'd1; force_to(0); tick(0);
    @(negedge clk); tk[0] = 1'b1; frc = 1'b1; fmode = 3'd2;
    @(negedge clk); tk = '0; frc = 1'b0;
    chk("R9 force over expiry", mode, 2);
    lim_hs = 8'd2; force_to(0);
    repeat (2) tick(0); force_to(0);
    repeat (2) tick(0); chk("R9 force clears count", mode, 0);
    tick(0); chk("R9 expire after clear", mode, 1);

    // R10
    lim_hs = 8'd10; force_to(0);
    repeat (5) tick(0);
    lim_hs = 8'd3;
    tick(0); chk("R10 lowered limit", mode, 1);
    lim_hs = 8'd4; force_to(0);
    repeat (3) tick(0);
    res_hs = 1'b1;
    tick(1); chk("R10 res switch keeps count", mode, 0);
    tick(1); chk("R10 res switch expire", mode, 1);
    res_hs = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: mode=%0d expected=finish", mode);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule